// File: doc/BRIEF.md
# Modem Status Register Unit

This block holds the modem-status word of a 16550-style UART register file. Four active-low modem lines enter from the pins: clear-to-send, data-set-ready, ring indicator and data-carrier-detect. Each line is brought into the system clock domain through a multi-flop synchronizer. The unit shows the present level of every line and keeps a sticky change flag for each one. For the ring line, the flag records only the return from active to inactive.

Software reads the word through a simple read port made of a strobe and an address. The read data is combinational in the strobe cycle. A read that hits the status offset returns the flags as they stood, then clears them at the closing clock edge. An interrupt-enable input qualifies a level-sensitive modem-status interrupt. The synchronizers treat every line as deasserted while reset is held. Because of this, a line that is already asserted when reset ends produces a change flag.

Top module: `modem_status_unit`

## Requirements
- R1: While reset is applied and after it, with all lines deasserted, a status read returns 0x00000000 and `msi_irq` is low. Bits 31..8 of `rd_data` are zero at all times.
- R2: Bits 7, 6, 5 and 4 of the status word show the inverted synchronized level of `dcd_in_n`, `ri_in_n`, `dsr_in_n` and `cts_in_n`. A change shows there no more than two clock edges after it reaches the pin.
- R3: Bit 0 (cts change), bit 1 (dsr change) and bit 3 (dcd change) set when the synchronized line changes level, in either direction. Each bit stays set until a clearing read.
- R4: Bit 2 sets only when `ri_in_n` goes from low to high. A high-to-low change leaves it clear.
- R5: A read with `rd_en` high and `rd_addr` equal to 0x18 returns, in the same cycle, the word with the flags as they stood before the read. At that clock edge, bits 3..0 are cleared.
- R6: A read at any other address returns zero and leaves the flags unchanged.
- R7: A change event that falls in the same cycle as a clearing read leaves its flag set.
- R8: The lines are held deasserted through reset. A cts, dsr or dcd line that is low when reset ends therefore sets its change flag. A low ring line does not set bit 2.
- R9: `msi_irq` is high exactly when `int_enable` is high and any of bits 3..0 is set, no matter whether the flag or the enable came first. It falls in the cycle after a clearing read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cts_in_n | input | 1 | Clear-to-send line, active low, asynchronous |
| dsr_in_n | input | 1 | Data-set-ready line, active low, asynchronous |
| ri_in_n | input | 1 | Ring indicator line, active low, asynchronous |
| dcd_in_n | input | 1 | Carrier detect line, active low, asynchronous |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W (8) | Register byte offset |
| rd_data | output | DATA_W (32) | Read data, valid in the strobe cycle |
| int_enable | input | 1 | Modem-status interrupt enable |
| msi_irq | output | 1 | Modem-status interrupt, level |

## Verification
The bench releases reset while clear-to-send and ring are both asserted. If the design skipped the deasserted reset level, no cts flag would appear. If it treated any ring edge as a trailing edge, a false ring flag would appear. Ring is driven in both directions, and a line is pulsed away and back between reads, so that an edge-only detector and a level-compare detector give different results. A read at a wrong offset is checked for zero data and for leaving the flags intact, which catches a decoder that clears on any strobe. A change is timed to land in the exact cycle of a clearing read: a design that lets the clear win would lose that event. The interrupt test raises the flag before the enable, which exposes an interrupt that is gated on edges instead of levels.

// File: rtl/msu_pkg.sv
// Package: shared line indices and widths for the modem status unit.
// Assumes the four modem lines keep one fixed index order in every vector.
package msu_pkg;
    localparam int MSU_LINES = 4;
    localparam int LINE_CTS  = 0;
    localparam int LINE_DSR  = 1;
    localparam int LINE_RI   = 2;
    localparam int LINE_DCD  = 3;
    // Lines whose flag records only the inactive-going edge
    localparam logic [MSU_LINES-1:0] TRAIL_ONLY = 4'b0100;
    typedef logic [MSU_LINES-1:0] msu_lines_t;
endpackage

// File: rtl/msu_sync.sv
// Module: multi-flop synchronizer, one chain per bit.
// Assumes each input bit is independent; reset loads RESET_VAL so that
// lines read as deasserted while reset is held.
module msu_sync #(
    parameter int   WIDTH     = 4,
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    localparam int LAST = STAGES - 1;

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        // Shift the raw pin level through the stage chain
        always_ff @(posedge clk) begin
            if (!rst_n) chain <= {STAGES{RESET_VAL}};
            else        chain <= {chain[STAGES-2:0], din[b]};
        end
        assign dout[b] = chain[LAST];
    end
endmodule

// File: rtl/msu_change_detect.sv
// Module: per-line change detector working on synchronized active-low levels.
// Compares each level with a registered copy. Lines flagged in TRAIL_MASK
// report only the low-to-high (active-to-inactive) transition; others both.
// Assumes the previous copy resets to deasserted (high).
module msu_change_detect #(
    parameter int               WIDTH      = 4,
    parameter logic [WIDTH-1:0] TRAIL_MASK = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] lvl_n,
    output logic [WIDTH-1:0] evt
);
    logic [WIDTH-1:0] prev_n;

    // Remember last cycle's synchronized level
    always_ff @(posedge clk) begin
        if (!rst_n) prev_n <= '1;
        else        prev_n <= lvl_n;
    end

    for (genvar k = 0; k < WIDTH; k++) begin : g_line
        if (TRAIL_MASK[k]) begin : g_trail
            // Active (low) to inactive (high) only
            assign evt[k] = lvl_n[k] & ~prev_n[k];
            a_r4_trail_only: assert property (@(posedge clk) disable iff (!rst_n)
                evt[k] |=> prev_n[k]);
        end else begin : g_any
            // Any level change
            assign evt[k] = lvl_n[k] ^ prev_n[k];
        end
    end
endmodule

// File: rtl/msu_flags.sv
// Module: sticky change flags with read-to-clear.
// A set in the same cycle as a clear wins, so no event is lost.
// Assumes the clear is a single-cycle qualified read strobe.
module msu_flags #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] set,
    input  logic             clr,
    output logic [WIDTH-1:0] flag
);
    // Accumulate events, drop them on a clearing read
    always_ff @(posedge clk) begin
        if (!rst_n) flag <= '0;
        else        flag <= (flag & ~{WIDTH{clr}}) | set;
    end

    for (genvar k = 0; k < WIDTH; k++) begin : g_chk
        a_r3_set_source: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flag[k]) |-> $past(set[k]));
        a_r5_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
            (clr && !set[k]) |=> !flag[k]);
        a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            (clr && set[k]) |=> flag[k]);
    end
endmodule

// File: rtl/modem_status_unit.sv
// Module: modem status word of a UART register file (top).
// Synchronizes four active-low modem lines, reports their levels, keeps
// sticky change flags cleared by a read at STATUS_OFFSET, and drives a
// level interrupt qualified by int_enable. Assumes DATA_W > 8.
module modem_status_unit
    import msu_pkg::*;
#(
    parameter int               DATA_W        = 32,
    parameter int               ADDR_W        = 8,
    parameter logic [ADDR_W-1:0] STATUS_OFFSET = 8'h18,
    parameter int               SYNC_STAGES   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cts_in_n,
    input  logic              dsr_in_n,
    input  logic              ri_in_n,
    input  logic              dcd_in_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              int_enable,
    output logic              msi_irq
);
    localparam int WORD_USED = 2 * MSU_LINES;
    localparam int PAD_W     = DATA_W - WORD_USED;

    msu_lines_t pins_n, sync_n, evt, flags;
    logic       rd_hit;
    logic [WORD_USED-1:0] status_word;

    assign pins_n[LINE_CTS] = cts_in_n;
    assign pins_n[LINE_DSR] = dsr_in_n;
    assign pins_n[LINE_RI]  = ri_in_n;
    assign pins_n[LINE_DCD] = dcd_in_n;

    msu_sync #(.WIDTH(MSU_LINES), .STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(pins_n), .dout(sync_n));

    msu_change_detect #(.WIDTH(MSU_LINES), .TRAIL_MASK(TRAIL_ONLY)) u_detect (
        .clk(clk), .rst_n(rst_n), .lvl_n(sync_n), .evt(evt));

    msu_flags #(.WIDTH(MSU_LINES)) u_flags (
        .clk(clk), .rst_n(rst_n), .set(evt), .clr(rd_hit), .flag(flags));

    // Decode a read of the status offset
    assign rd_hit = rd_en && (rd_addr == STATUS_OFFSET);

    // Levels above flags, both in line index order
    assign status_word = {~sync_n, flags};

    // Return the word on a hit, zero otherwise
    always_comb begin
        rd_data = '0;
        if (rd_hit) rd_data = {{PAD_W{1'b0}}, status_word};
        a_r1_upper_zero: assert (rd_data[DATA_W-1:WORD_USED] == '0);
    end

    // Level interrupt while any flag is pending and enabled
    assign msi_irq = int_enable && (|flags);

    a_r9_irq_drop_by_read: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(msi_irq) && $past(int_enable) && int_enable) |-> $past(rd_hit));

    a_r4_ring_inactive: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[LINE_RI]) |-> $past(sync_n[LINE_RI]));

    for (genvar k = 0; k < MSU_LINES; k++) begin : g_hold
        a_r6_no_stray_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (!rd_hit && flags[k]) |=> flags[k]);
    end
endmodule

// File: tb/test_modem_status_unit.sv
module test_modem_status_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cts_in_n = 1'b0, dsr_in_n = 1'b1, ri_in_n = 1'b0, dcd_in_n = 1'b1;
    logic        rd_en = 1'b0;
    logic [7:0]  rd_addr = 8'h18;
    logic [31:0] rd_data;
    logic        int_enable = 1'b0;
    logic        msi_irq;
    int          checks = 0;
    int          fails = 0;

    always #2 clk = ~clk;

    modem_status_unit i_modem_status_unit (
        .clk(clk), .rst_n(rst_n), .cts_in_n(cts_in_n), .dsr_in_n(dsr_in_n),
        .ri_in_n(ri_in_n), .dcd_in_n(dcd_in_n), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .int_enable(int_enable), .msi_irq(msi_irq));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic do_read(input logic [7:0] addr, output logic [31:0] word);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = addr;
        #1 word = rd_data;
        @(negedge clk);
        rd_en = 1'b0; rd_addr = 8'h18;
    endtask

    // R1, R8: reset state, then release with cts and ring asserted
    task automatic t_reset();
        logic [31:0] w;
        repeat (3) @(negedge clk);
        rd_en = 1'b1;
        #1 check("R1 read during reset", rd_data, 32'h0);
        check("R1 irq during reset", {31'b0, msi_irq}, 32'h0);
        rd_en = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        settle();
        do_read(8'h18, w);
        check("R8 cts flag after reset, no ring flag", w, 32'h51);
        do_read(8'h18, w);
        check("R5 flags cleared by read", w, 32'h50);
    endtask

    // R4: ring trailing edge only
    task automatic t_ring();
        logic [31:0] w;
        ri_in_n = 1'b1; settle();
        do_read(8'h18, w);
        check("R4 ring low-to-high sets bit2", w, 32'h14);
        ri_in_n = 1'b0; settle();
        do_read(8'h18, w);
        check("R4 ring high-to-low leaves bit2 clear", w, 32'h50);
    endtask

    // R2, R3: levels and both-direction deltas
    task automatic t_deltas();
        logic [31:0] w;
        dsr_in_n = 1'b0; settle();
        do_read(8'h18, w);
        check("R3 dsr falling sets bit1", w, 32'h72);
        dcd_in_n = 1'b0; settle();
        do_read(8'h18, w);
        check("R2 dcd level and R3 bit3", w, 32'hF8);
        dcd_in_n = 1'b1; cts_in_n = 1'b1; settle();
        do_read(8'h18, w);
        check("R3 rising dcd and cts", w, 32'h69);
        dsr_in_n = 1'b1; settle();
        dsr_in_n = 1'b0; settle();
        do_read(8'h18, w);
        check("R3 pulse away and back latches", w, 32'h62);
    endtask

    // R6: other offset reads zero and clears nothing
    task automatic t_wrong_addr();
        logic [31:0] w;
        dcd_in_n = 1'b0; settle();
        do_read(8'h14, w);
        check("R6 other offset reads zero", w, 32'h0);
        do_read(8'h18, w);
        check("R6 flag survived other read", w, 32'hE8);
    endtask

    // R9: interrupt level, enable after flag, drop after read
    task automatic t_irq();
        logic [31:0] w;
        dcd_in_n = 1'b1; settle();
        check("R9 irq low while disabled", {31'b0, msi_irq}, 32'h0);
        int_enable = 1'b1;
        #1 check("R9 irq on when enabled after flag", {31'b0, msi_irq}, 32'h1);
        do_read(8'h18, w);
        check("R5 read returns pre-clear flag", w, 32'h68);
        #1 check("R9 irq dropped after read", {31'b0, msi_irq}, 32'h0);
    endtask

    // R7: event in the clearing-read cycle
    task automatic t_collision();
        logic [31:0] w;
        @(negedge clk) cts_in_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = 8'h18;
        #1 w = rd_data;
        check("R7 read before event lands", w, 32'h70);
        @(negedge clk);
        rd_en = 1'b0;
        #1 check("R7 irq still high after colliding read", {31'b0, msi_irq}, 32'h1);
        do_read(8'h18, w);
        check("R7 event kept through clear", w, 32'h71);
    endtask

    initial begin
        t_reset();
        t_ring();
        t_deltas();
        t_wrong_addr();
        t_irq();
        t_collision();
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 4);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end
endmodule